// File: doc/BRIEF.md
# Fixed-Point to Half-Precision Converter

This block turns a signed fixed-point word into a 16-bit binary floating-point value. The input word carries a sign bit on top, then a 15-bit integer magnitude, then a 16-bit fraction magnitude. It is sign-magnitude, so a negative value differs from its positive twin only in bit 31. The block locates the most significant set bit of the magnitude and shifts it into the normalised position. It then forms the biased exponent and keeps the ten fraction bits that follow the hidden leading one. Lower bits are dropped without rounding.

The converter sits in a datapath as a single pipeline stage. A word presented with its valid strobe appears converted on the output one clock later, together with a flag that reports whether any set bit was lost. Magnitudes too small for a normal encoding come out as subnormals. Zero keeps its sign.

Top module: `fx2half_conv`

## Requirements
- R1: The output is packed as sign in bit 15, a 5-bit exponent in bits 14..10 and a 10-bit fraction in bits 9..0. The exponent holds the power of two plus 15, so 0.125 (input 0x00002000) gives 0x3000.
- R2: For a normal result the fraction holds the ten bits that follow the leading one, and lower bits are truncated. 14.125 (0x000E2000) gives 0x4B10, and input 0x00032418 (about 3.141) gives 0x4248.
- R3: The output sign bit equals input bit 31, and the other output bits do not depend on it. -14.125 (0x800E2000) gives 0xCB10.
- R4: A zero magnitude gives exponent 0 and fraction 0 with the input sign kept (0x80000000 gives 0x8000), and the inexact flag is 0.
- R5: A magnitude below 2^-14 (raw magnitude 1 to 3) gives exponent 0 and a fraction equal to the raw magnitude shifted left by 8, with no hidden one. Raw magnitude 4 gives 0x0400.
- R6: The inexact flag is 1 exactly when at least one set magnitude bit is dropped by the truncation.
- R7: valid_out equals valid_in of the previous clock, and a synchronous active-high reset clears valid_out.
- R8: The data and inexact outputs load only in a clock where valid_in is 1, and hold their value otherwise.
- R9: The exponent field never reaches 31. The largest input 0x7FFFFFFF gives 0x77FF with inexact set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Input word is valid this cycle |
| fx_in | input | 32 | Sign-magnitude fixed-point input: sign, integer, fraction |
| valid_out | output | 1 | Output word is valid |
| half_out | output | 16 | Half-precision result |
| inexact | output | 1 | A set bit was lost to truncation |

## Verification
Normalisation and truncation loss can happen in the same conversion. This occurs whenever the leading one sits more than ten places above the lowest set bit. The largest magnitude and the near-pi value bring this about on purpose. Random words shifted right by random amounts spread the leading one over every position, mostly with set bits below the kept field. Each result is judged against a bench model that computes the fraction and the loss mask with plain arithmetic shifts. The other near-coincident case is a word at the subnormal edge (raw 3 versus 4), which must switch encoding with no loss.

// File: rtl/fx2h_pkg.sv
package fx2h_pkg;
   // Default geometry of the fixed-point input and the float output
   localparam int unsigned DEF_INT_W  = 15;
   localparam int unsigned DEF_FRAC_W = 16;
   localparam int unsigned DEF_EXP_W  = 5;
   localparam int unsigned DEF_MAN_W  = 10;

   // Exponent bias for an exponent field of the given width
   function automatic int exp_bias(input int unsigned exp_w);
      return (1 << (exp_w - 1)) - 1;
   endfunction
endpackage

// File: rtl/fx2h_lead_one.sv
module fx2h_lead_one #(
   parameter int unsigned MAG_W = 31,
   localparam int unsigned POS_W = $clog2(MAG_W)
) (
   input  logic [MAG_W-1:0] mag,
   output logic [POS_W-1:0] pos,
   output logic             is_zero
);
   if (MAG_W < 2) begin : g_chk_w
      $error("fx2h_lead_one: MAG_W must be at least 2");
   end

   // Later iterations override earlier ones, leaving the highest set bit
   always_comb begin
      pos = '0;
      for (int i = 0; i < MAG_W; i++) begin
         if (mag[i]) pos = POS_W'(i);
      end
   end

   assign is_zero = ~|mag;
endmodule

// File: rtl/fx2h_pack.sv
module fx2h_pack #(
   parameter int unsigned MAG_W  = 31,
   parameter int unsigned FRAC_W = 16,
   parameter int unsigned EXP_W  = 5,
   parameter int unsigned MAN_W  = 10,
   localparam int unsigned POS_W = $clog2(MAG_W)
) (
   input  logic [MAG_W-1:0] mag,
   input  logic [POS_W-1:0] pos,
   input  logic             is_zero,
   output logic [EXP_W-1:0] exp_f,
   output logic [MAN_W-1:0] man_f,
   output logic             lost
);
   import fx2h_pkg::*;

   localparam int BIAS    = exp_bias(EXP_W);
   localparam int EXP_OFS = int'(FRAC_W) - BIAS;           // biased exp = pos - EXP_OFS
   localparam int SUB_SH  = int'(MAN_W) + BIAS - 1 - int'(FRAC_W);
   localparam int SHW     = MAG_W - 1;                      // width below the leading one
   localparam int LOW_W   = SHW - int'(MAN_W);

   if (EXP_OFS < 0 || SUB_SH < 0) begin : g_chk_range
      $error("fx2h_pack: fraction width does not reach the subnormal range");
   end
   if (SUB_SH + EXP_OFS + 1 > int'(MAN_W)) begin : g_chk_sub
      $error("fx2h_pack: subnormal fraction does not fit the mantissa");
   end
   if (int'(MAG_W) - 1 - EXP_OFS >= (1 << EXP_W) - 1) begin : g_chk_ovf
      $error("fx2h_pack: largest magnitude overflows the exponent");
   end
   if (LOW_W < 1) begin : g_chk_low
      $error("fx2h_pack: magnitude too narrow for the mantissa");
   end

   logic [SHW-1:0]   norm;
   logic [MAN_W-1:0] sub_man;
   logic             subnorm;

   // Leading one moved just past the top of norm, so it falls off
   assign norm    = SHW'(mag << (POS_W'(SHW) - pos));
   assign subnorm = (int'(pos) <= EXP_OFS);

   if (SUB_SH == 0) begin : g_sub_direct
      assign sub_man = MAN_W'(mag);
   end else begin : g_sub_shift
      assign sub_man = MAN_W'(mag << SUB_SH);
   end

   always_comb begin
      if (is_zero) begin
         exp_f = '0;
         man_f = '0;
         lost  = 1'b0;
      end else if (subnorm) begin
         exp_f = '0;
         man_f = sub_man;
         lost  = 1'b0;
      end else begin
         exp_f = EXP_W'(int'(pos) - EXP_OFS);
         man_f = norm[SHW-1 -: MAN_W];
         lost  = |norm[LOW_W-1:0];
      end
   end
endmodule

// File: rtl/fx2half_conv.sv
module fx2half_conv #(
   parameter int unsigned INT_W  = fx2h_pkg::DEF_INT_W,
   parameter int unsigned FRAC_W = fx2h_pkg::DEF_FRAC_W,
   parameter int unsigned EXP_W  = fx2h_pkg::DEF_EXP_W,
   parameter int unsigned MAN_W  = fx2h_pkg::DEF_MAN_W,
   localparam int unsigned MAG_W = INT_W + FRAC_W,
   localparam int unsigned IN_W  = MAG_W + 1,
   localparam int unsigned OUT_W = 1 + EXP_W + MAN_W,
   localparam int unsigned POS_W = $clog2(MAG_W)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             valid_in,
   input  logic [IN_W-1:0]  fx_in,
   output logic             valid_out,
   output logic [OUT_W-1:0] half_out,
   output logic             inexact
);
   logic [MAG_W-1:0] mag;
   logic [POS_W-1:0] pos;
   logic             is_zero;
   logic [EXP_W-1:0] exp_f;
   logic [MAN_W-1:0] man_f;
   logic             lost;

   assign mag = fx_in[MAG_W-1:0];

   fx2h_lead_one #(.MAG_W(MAG_W)) u_lead (
      .mag(mag), .pos(pos), .is_zero(is_zero)
   );

   fx2h_pack #(.MAG_W(MAG_W), .FRAC_W(FRAC_W), .EXP_W(EXP_W), .MAN_W(MAN_W)) u_pack (
      .mag(mag), .pos(pos), .is_zero(is_zero),
      .exp_f(exp_f), .man_f(man_f), .lost(lost)
   );

   always_ff @(posedge clk) begin
      if (rst) valid_out <= 1'b0;
      else     valid_out <= valid_in;
   end

   always_ff @(posedge clk) begin
      if (valid_in) begin
         half_out <= {fx_in[IN_W-1], exp_f, man_f};
         inexact  <= lost;
      end
   end

   AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
      valid_out == $past(valid_in)); // R7
   AST_SIGN_COPY: assert property (@(posedge clk) disable iff (rst)
      valid_in |=> half_out[OUT_W-1] == $past(fx_in[IN_W-1])); // R3
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      !valid_in |=> $stable(half_out) && $stable(inexact)); // R8
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      valid_out |-> half_out[OUT_W-2 -: EXP_W] != {EXP_W{1'b1}}); // R9
   AST_ZERO_EXACT: assert property (@(posedge clk) disable iff (rst)
      (valid_in && fx_in[MAG_W-1:0] == '0) |=> half_out[OUT_W-2:0] == '0 && !inexact); // R4
   AST_SUBNORM_EXACT: assert property (@(posedge clk) disable iff (rst)
      (valid_out && half_out[OUT_W-2 -: EXP_W] == '0) |-> !inexact); // R5
endmodule

// File: tb/tb_fx2half_conv.sv
`timescale 1ns/1ps
module tb_fx2half_conv;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        valid_in = 1'b0;
   logic [31:0] fx_in = '0;
   logic        valid_out;
   logic [15:0] half_out;
   logic        inexact;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   fx2half_conv dut (
      .clk(clk), .rst(rst), .valid_in(valid_in), .fx_in(fx_in),
      .valid_out(valid_out), .half_out(half_out), .inexact(inexact)
   );

   // Expected conversion from the requirements, by arithmetic shifts
   function automatic logic [16:0] model(input logic [31:0] w);
      logic [30:0] m = w[30:0];
      int p = -1;
      logic [9:0] f;
      logic lx;
      for (int i = 0; i < 31; i++) if (m[i]) p = i;
      if (p < 0) return {1'b0, w[31], 15'h0};                // R4
      if (p < 2) return {1'b0, w[31], 5'd0, 10'(m << 8)};     // R5
      if (p >= 10) f = 10'(m >> (p - 10));
      else         f = 10'(m << (10 - p));
      lx = (p > 10) ? ((m & ((31'd1 << (p - 10)) - 31'd1)) != 0) : 1'b0;
      return {lx, w[31], 5'(p - 1), f};                        // R1 R2 R6
   endfunction

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic convert(input string req, input logic [31:0] w);
      logic [16:0] e = model(w);
      @(negedge clk);
      fx_in = w;
      valid_in = 1'b1;
      @(negedge clk);
      valid_in = 1'b0;
      check({req, " data"}, {16'h0, half_out}, {16'h0, e[15:0]});
      check({req, " inexact R6"}, {31'h0, inexact}, {31'h0, e[16]});
      check("R7 valid", {31'h0, valid_out}, 32'h1);
   endtask

   task automatic expect_word(input string req, input logic [31:0] w, input logic [15:0] h, input logic ix);
      convert(req, w);
      check({req, " fixed"}, {15'h0, ix, half_out}, {15'h0, ix ? inexact : 1'b0, h});
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] held;
      logic        held_ix;
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      check("R7 reset", {31'h0, valid_out}, 32'h0);
      rst = 1'b0;
      @(negedge clk);
      check("R7 idle", {31'h0, valid_out}, 32'h0);

      expect_word("R2 14.125",  32'h000E2000, 16'h4B10, 1'b0);
      expect_word("R3 -14.125", 32'h800E2000, 16'hCB10, 1'b0);
      expect_word("R1 0.125",   32'h00002000, 16'h3000, 1'b0);
      expect_word("R2 3.141",   32'h00032418, 16'h4248, 1'b1);
      check("R6 3.141 lost bits", {31'h0, inexact}, 32'h1);
      expect_word("R4 -zero",   32'h80000000, 16'h8000, 1'b0);
      expect_word("R4 +zero",   32'h00000000, 16'h0000, 1'b0);
      expect_word("R5 2^-16",   32'h00000001, 16'h0100, 1'b0);
      expect_word("R5 raw3",    32'h80000003, 16'h8300, 1'b0);
      expect_word("R5 2^-14",   32'h00000004, 16'h0400, 1'b0);
      expect_word("R9 max",     32'h7FFFFFFF, 16'h77FF, 1'b1);
      check("R9 max inexact", {31'h0, inexact}, 32'h1);

      // R8: new data without valid leaves outputs untouched
      held = half_out;
      held_ix = inexact;
      @(negedge clk);
      fx_in = 32'h00000001;
      @(negedge clk);
      check("R8 hold data", {16'h0, half_out}, {16'h0, held});
      check("R8 hold flag", {31'h0, inexact}, {31'h0, held_ix});
      check("R7 valid low", {31'h0, valid_out}, 32'h0);

      // R3: same magnitude, both signs, random
      for (int k = 0; k < 20; k++) begin
         logic [31:0] w = {1'b0, 31'($urandom)};
         convert("R3 pos", w);
         held = half_out;
         convert("R3 neg", w | 32'h80000000);
         check("R3 sign-only", {16'h0, half_out}, {16'h0, held | 16'h8000});
      end

      for (int k = 0; k < 400; k++) begin
         logic [31:0] w = $urandom >> ($urandom % 32);
         w[31] = $urandom % 2;
         convert("R2 random", w);
      end

      // R7: back-to-back stream
      @(negedge clk);
      valid_in = 1'b1;
      for (int k = 0; k < 8; k++) begin
         fx_in = 32'h00010000 << k;
         @(negedge clk);
         check("R7 stream", {16'h0, half_out}, {16'h0, 16'h3C00 + 16'(k << 10)});
         check("R7 stream valid", {31'h0, valid_out}, 32'h1);
      end
      valid_in = 1'b0;
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check("R7 reset clears", {31'h0, valid_out}, 32'h0);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule